// File: doc/BRIEF.md
# Shared Packet Buffer Page Allocator

This block hands out pages of a buffer that is shared by the host transmit path and the network receive path. Each request asks for one page. The response arrives one cycle after the request is accepted. It carries a success flag, the kind of request it answers and the page number granted, which is always the lowest-numbered free page. Pages go back to the pool through a release port. The block drives the current free-page count and the fixed buffer size as plain status outputs.

A host-programmable reservation protects transmit space from receive traffic. A new receive packet is refused while the free-page count is below the reservation, and the sender then drops that packet as an overrun. Once a receive packet has been granted its first page, it is in progress. Its later page requests skip the reservation test until the receive engine signals the end of the packet, so raising the reservation never cuts a packet short. The reservation can be rewritten on any cycle. Receive acceptance comes back by itself as soon as releases lift the free count to the reservation again.

Top module: `palloc_top`

## Requirements
- R1: After reset all 16 pages are free: `free_pages` = 16, `rsp_valid` = 0 and `rel_err` = 0.
- R2: An accepted request produces exactly one response, with `rsp_valid` = 1, on the next clock. A successful response carries the lowest-numbered free page in `rsp_page` (0 to 15). A failed response carries page 0.
- R3: When both requests are valid in the same cycle, the receive request is served and `tx_req_ready` is 0. The host holds its request, and it is served on the next cycle. `rsp_rx` = 1 marks a response to a receive request.
- R4: A receive request with no packet in progress fails (`rsp_ok` = 0) when `free_pages` < `reserve_pages`. Its page stays free.
- R5: With `reserve_pages` = 0, receive requests are granted until no page is free.
- R6: A transmit request fails only when no page is free. The reservation never blocks transmit.
- R7: A successful receive grant starts a packet in progress. Further receive requests of that packet ignore the reservation until `rx_pkt_done` is pulsed. A failed receive request also ends the packet in progress.
- R8: `rel_valid` with an allocated `rel_page` frees that page on the next clock. A refused new receive is accepted again once releases raise `free_pages` to at least `reserve_pages`.
- R9: Releasing a page that is already free changes nothing and sets `rel_err`, which stays set until reset.
- R10: `total_pages` always reads 16.
- R11: `free_pages` equals the number of pages that are not allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req_valid | input | 1 | Host asks for one transmit page |
| tx_req_ready | output | 1 | Transmit request accepted this cycle (0 while a receive request is present) |
| rx_req_valid | input | 1 | Receive engine asks for one page |
| rx_req_ready | output | 1 | Receive request accepted (always 1) |
| rx_pkt_done | input | 1 | Pulse: current receive packet has ended |
| rsp_valid | output | 1 | Response present (no back-pressure) |
| rsp_ok | output | 1 | 1 = page granted, 0 = refused |
| rsp_rx | output | 1 | 1 = response to a receive request |
| rsp_page | output | 4 | Granted page number |
| rel_valid | input | 1 | Release strobe |
| rel_page | input | 4 | Page being released |
| reserve_pages | input | 5 | Pages reserved for transmit, 0 to 16 |
| free_pages | output | 5 | Current number of free pages |
| total_pages | output | 5 | Buffer size in pages |
| rel_err | output | 1 | Sticky flag: a free page was released |

## Verification
The assertions assume that `rx_pkt_done` never arrives in the same cycle as a receive request and that the host keeps `tx_req_valid` high until `tx_req_ready` accepts it. The stimulus ends every receive packet on a cycle of its own and repeats a blocked transmit request on the cycle after the conflict. Responses have no ready signal, so the stimulus never stalls them. Reservation changes are made between requests, at values both below and above the free count.

// File: rtl/palloc_pkg.sv
package palloc_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_TX   = 2'd1,
    KIND_RX   = 2'd2
  } req_kind_e;
endpackage

// File: rtl/palloc_map.sv
module palloc_map #(
  parameter int PAGES = 16,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_idx,
  output logic [PW-1:0] low_idx,
  output logic          any_free,
  output logic [CW-1:0] free_cnt,
  output logic          rel_bad
);
  logic [PAGES-1:0] used_q, used_d;

  // lowest free page: scan downward so the smallest index wins
  always_comb begin
    low_idx = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (!used_q[i]) low_idx = PW'(i);
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < PAGES; i++)
      free_cnt = free_cnt + CW'(!used_q[i]);
  end

  assign any_free = free_cnt != '0;
  assign rel_bad  = rel_en && !used_q[rel_idx];

  always_comb begin
    used_d = used_q;
    if (alloc_en) used_d[low_idx] = 1'b1;
    if (rel_en && used_q[rel_idx]) used_d[rel_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end
endmodule

// File: rtl/palloc_admit.sv
module palloc_admit
  import palloc_pkg::*;
#(
  parameter int PAGES = 16,
  localparam int CW = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_v,
  input  logic          rx_v,
  input  logic          rx_end,
  input  logic          any_free,
  input  logic [CW-1:0] free_cnt,
  input  logic [CW-1:0] reserve,
  output req_kind_e     kind,
  output logic          grant_ok,
  output logic          rx_active,
  output logic          tx_rdy
);
  logic active_q;

  assign rx_active = active_q;
  assign tx_rdy    = !rx_v;

  always_comb begin
    if (rx_v)      kind = KIND_RX;
    else if (tx_v) kind = KIND_TX;
    else           kind = KIND_NONE;
  end

  always_comb begin
    unique case (kind)
      KIND_TX: grant_ok = any_free;
      KIND_RX: grant_ok = any_free && (active_q || free_cnt >= reserve);
      default: grant_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              active_q <= 1'b0;
    else if (rx_end)         active_q <= 1'b0;
    else if (kind == KIND_RX) active_q <= grant_ok;
  end
endmodule

// File: rtl/palloc_top.sv
module palloc_top
  import palloc_pkg::*;
#(
  parameter int PAGES = 16,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req_valid,
  output logic          tx_req_ready,
  input  logic          rx_req_valid,
  output logic          rx_req_ready,
  input  logic          rx_pkt_done,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic          rsp_rx,
  output logic [PW-1:0] rsp_page,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_page,
  input  logic [CW-1:0] reserve_pages,
  output logic [CW-1:0] free_pages,
  output logic [CW-1:0] total_pages,
  output logic          rel_err
);
  req_kind_e     kind;
  logic          grant_ok, any_free, rel_bad, rx_active;
  logic [PW-1:0] low_idx;

  palloc_map #(.PAGES(PAGES)) u_map (
    .clk(clk), .rst_n(rst_n), .alloc_en(grant_ok), .rel_en(rel_valid),
    .rel_idx(rel_page), .low_idx(low_idx), .any_free(any_free),
    .free_cnt(free_pages), .rel_bad(rel_bad)
  );

  palloc_admit #(.PAGES(PAGES)) u_admit (
    .clk(clk), .rst_n(rst_n), .tx_v(tx_req_valid), .rx_v(rx_req_valid),
    .rx_end(rx_pkt_done), .any_free(any_free), .free_cnt(free_pages),
    .reserve(reserve_pages), .kind(kind), .grant_ok(grant_ok),
    .rx_active(rx_active), .tx_rdy(tx_req_ready)
  );

  assign rx_req_ready = 1'b1;
  assign total_pages  = CW'(PAGES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rx    <= 1'b0;
      rsp_page  <= '0;
      rel_err   <= 1'b0;
    end else begin
      rsp_valid <= kind != KIND_NONE;
      rsp_ok    <= grant_ok;
      rsp_rx    <= kind == KIND_RX;
      rsp_page  <= grant_ok ? low_idx : '0;
      if (rel_bad) rel_err <= 1'b1;
    end
  end
endmodule

// File: rtl/palloc_chk.sv
module palloc_chk #(
  parameter int PAGES = 16,
  localparam int CW = $clog2(PAGES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_req_valid,
  input logic          tx_req_ready,
  input logic          rx_req_valid,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic          rel_valid,
  input logic [CW-1:0] reserve_pages,
  input logic [CW-1:0] free_pages,
  input logic [CW-1:0] total_pages,
  input logic          rel_err,
  input logic          rx_active
);
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_pages <= total_pages); // R11
  AST_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req_valid |-> !tx_req_ready); // R3
  AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req_valid || (tx_req_valid && tx_req_ready)) |=> rsp_valid); // R2
  AST_TX_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && tx_req_ready && free_pages != '0) |=> rsp_ok); // R6
  AST_RX_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req_valid && !rx_active && free_pages < reserve_pages) |=> !rsp_ok); // R4
  AST_RX_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req_valid && rx_active && free_pages != '0) |=> rsp_ok); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err); // R9
  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && !$past(rel_valid)) |-> free_pages == $past(free_pages) - 1'b1); // R11
endmodule

bind palloc_top palloc_chk #(.PAGES(PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_req_valid(tx_req_valid),
  .tx_req_ready(tx_req_ready), .rx_req_valid(rx_req_valid),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rel_valid(rel_valid),
  .reserve_pages(reserve_pages), .free_pages(free_pages),
  .total_pages(total_pages), .rel_err(rel_err), .rx_active(rx_active)
);

// File: tb/sim_palloc_top.sv
module sim_palloc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_v = 0, rx_v = 0, rx_done = 0, rel_v = 0;
  logic [3:0] rel_p = '0;
  logic [4:0] reserve = '0;
  logic tx_rdy, rx_rdy, rsp_valid, rsp_ok, rsp_rx, rel_err;
  logic [3:0] rsp_page;
  logic [4:0] free_pages, total_pages;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  bit used[16];
  bit m_busy = 0, m_err = 0;
  bit e_valid = 0, e_ok = 0, e_rx = 0;
  int e_page = 0;

  always #4 clk = ~clk;

  palloc_top u0 (
    .clk(clk), .rst_n(rst_n), .tx_req_valid(tx_v), .tx_req_ready(tx_rdy),
    .rx_req_valid(rx_v), .rx_req_ready(rx_rdy), .rx_pkt_done(rx_done),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rx(rsp_rx), .rsp_page(rsp_page),
    .rel_valid(rel_v), .rel_page(rel_p), .reserve_pages(reserve),
    .free_pages(free_pages), .total_pages(total_pages), .rel_err(rel_err)
  );

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_free();
    int n = 0;
    for (int i = 0; i < 16; i++) if (!used[i]) n++;
    return n;
  endfunction

  function automatic int m_low();
    for (int i = 0; i < 16; i++) if (!used[i]) return i;
    return 0;
  endfunction

  task automatic compare_all();
    check(rsp_valid == e_valid, tag, "rsp_valid", rsp_valid, e_valid);
    if (e_valid) begin
      check(rsp_ok == e_ok, tag, "rsp_ok", rsp_ok, e_ok);
      check(rsp_rx == e_rx, "R3", "rsp_rx", rsp_rx, e_rx);
      check(int'(rsp_page) == e_page, "R2", "rsp_page", rsp_page, e_page);
    end
    check(int'(free_pages) == m_free(), "R11", "free_pages", free_pages, m_free());
    check(total_pages == 5'd16, "R10", "total_pages", total_pages, 16);
    check(rel_err == m_err, "R9", "rel_err", rel_err, m_err);
  endtask

  task automatic cyc(bit t, bit r, bit d, bit rv, int rp);
    int fr, lo;
    bit ok;
    @(negedge clk);
    tx_v = t; rx_v = r; rx_done = d; rel_v = rv; rel_p = 4'(rp);
    #1;
    check(tx_rdy == !r, "R3", "tx_req_ready", tx_rdy, !r);
    fr = m_free(); lo = m_low(); ok = 0;
    e_valid = r || t; e_rx = r;
    if (r) ok = (fr > 0) && (m_busy || fr >= int'(reserve));
    else if (t) ok = fr > 0;
    e_ok = ok; e_page = ok ? lo : 0;
    if (rv) begin
      if (used[rp]) used[rp] = 0; else m_err = 1;
    end
    if (ok) used[lo] = 1;
    if (d) m_busy = 0; else if (r) m_busy = ok;
    @(posedge clk); #1;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) used[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    tag = "R1";
    check(free_pages == 5'd16, "R1", "free after reset", free_pages, 16);
    check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(rel_err == 0, "R1", "rel_err after reset", rel_err, 0);
    cyc(0, 0, 0, 0, 0);

    tag = "R2"; // transmit grants take pages 0,1,2
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);

    tag = "R3"; // conflict: receive first, host retried next cycle
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 0, 0, 0, 0);

    tag = "R4"; // reserve above free: new receive refused
    reserve = 5'd14;
    cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    tag = "R6"; // transmit unaffected by reservation
    cyc(1, 0, 0, 0, 0);

    tag = "R7"; // in-progress receive survives a raised reservation
    reserve = 5'd0;
    cyc(0, 1, 0, 0, 0);
    reserve = 5'd16;
    cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 1, 0, 0, 0);

    tag = "R8"; // releases bring receive back
    reserve = 5'd10;
    for (int p = 0; p < 6; p++) cyc(0, 0, 0, 1, p);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);

    tag = "R9"; // double release ignored, flag sticks
    cyc(0, 0, 0, 1, 12);
    cyc(0, 0, 0, 1, 3);
    cyc(0, 0, 0, 1, 3);
    cyc(0, 0, 0, 0, 0);

    tag = "R5"; // no reservation: receive fills the buffer
    reserve = 5'd0;
    for (int i = 0; i < 14; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 1, 0, 0, 0);
    tag = "R6";
    cyc(1, 0, 0, 0, 0);
    tag = "R8"; // release with grant in the same cycle
    cyc(1, 0, 0, 1, 9);
    cyc(1, 0, 0, 1, 15);
    cyc(0, 0, 0, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule